// File: doc/BRIEF.md
# CEC Frame Receiver

This block listens to a single-wire CEC bus through a slow timebase enable (nominally 32.768 kHz, one `tick` per period) and turns valid line activity into stored message bytes. Every low and high phase is timed in ticks from the most recent falling edge. A start bit is accepted only when its low phase, its high phase and its full period each fall inside their own window. Data bits decode from their low time, and period and high-time limits catch malformed bits.

Once the first byte is complete, the receiver compares its destination nibble against a programmed own address that carries a valid flag. A matching frame is stored, and the receiver pulls the line low in every acknowledge slot of that frame. A broadcast frame is stored without being acknowledged. Completion, errors and overflow are reported through a two-bit status code, a length field holding the byte count minus one, a message count and a sticky interrupt. Software releases a message with a command write, can suspend reception with another command, and can empty the store with a level clear input.

The bus output `ack_pull` must be combined with the other drivers as a wired-AND: the line is low while any driver pulls it low.

Top module: `cec_frame_rx`

## Requirements
- R1: After reset, rx_status is 0 (idle), rx_len is 0, rx_count is 0, rx_irq is 0 and ack_pull is 0.
- R2: A start bit is accepted only when all three windows hold: low time 115..128 ticks, high time 20..33 ticks and period 141..154 ticks. If any of them fails, the following bits store nothing, drive no acknowledge and leave the status at 0.
- R3: Each byte takes ten bits: eight data bits (most significant first), an end-of-message bit and an acknowledge bit. A bit whose low time is 13..26 ticks reads as 1, and one whose low time is 43..56 ticks reads as 0. Byte n of a frame is read on rd_data when rd_idx is n.
- R4: Inside an accepted frame, each of the following ends the frame with rx_status 3 and rx_irq set, and leaves rx_count unchanged: a low time that fits neither window, a low time of 111 ticks or more, a bit period under 67 ticks, or a high time over 92 ticks.
- R5: The destination is the low nibble of the first byte. A frame is accepted only if own_addr[4] (valid flag) is 1 and the destination equals own_addr[3:0] or 15 (broadcast). Any other frame leaves the status, the count and the stored bytes unchanged.
- R6: For an accepted frame whose destination equals own_addr[3:0], ack_pull goes high at the falling edge of every acknowledge slot and is held for 49 ticks. It is never driven for broadcast or foreign frames.
- R7: When the acknowledge slot of a byte whose end-of-message bit is 1 has ended, rx_status becomes 2, rx_len becomes the byte count minus 1, rx_count increments and rx_irq is set.
- R8: A frame longer than DEPTH (16) bytes ends with rx_status 3, rx_len 15 and its first 16 bytes kept.
- R9: While rx_status is 2 or 3, frames are ignored and not acknowledged. A command write of 1 or 3 returns the status to 0 and, if the status was 2, decrements rx_count.
- R10: Writing command 2 suspends reception, including any frame in progress. Writing any other command resumes it.
- R11: While clr_buf is 1, rx_status, rx_len and rx_count read 0, every stored byte reads 0 and the bus is ignored. Returning clr_buf to 0 restores normal reception.
- R12: rx_irq stays set until a pulse on irq_clr.
- R13: rx_status reads 1 (busy) from acceptance of the first byte until the frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase enable, one pulse per timing unit |
| cec_in | input | 1 | Bus line level (asynchronous) |
| ack_pull | output | 1 | 1 pulls the bus line low |
| own_addr | input | 5 | [3:0] own logical address, [4] valid flag |
| cmd_wr | input | 1 | Command write strobe |
| cmd | input | 2 | Command: 0 none, 1 release, 2 suspend, 3 release and advance |
| clr_buf | input | 1 | Level: empties the store while 1 |
| irq_clr | input | 1 | Clears rx_irq |
| rd_idx | input | IDX_W | Byte index to read |
| rd_data | output | 8 | Stored byte at rd_idx |
| rx_status | output | 2 | 0 idle, 1 busy, 2 done, 3 error |
| rx_len | output | IDX_W | Stored byte count minus one |
| rx_count | output | CNT_W | Completed messages awaiting release |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The state that goes wrong in this block is its bit and byte position within a frame, together with the accept and own-address decisions. A wrong bit index appears at the ports within one byte time: data reads back shifted, or the acknowledge lands in the wrong slot, which the bench sees as a low line at the sample point of an acknowledge bit. A faulty window comparator shows up within the same frame, as an error status where completion was expected or the reverse. A faulty release or clear path shows up as a status or count that does not return to zero on the next read.

// File: rtl/cec_frame_rx.sv
module cec_frame_rx #(
  parameter int DEPTH         = 16,
  parameter int CNT_W         = 4,
  parameter int START_LO_MIN  = 115,
  parameter int START_LO_MAX  = 128,
  parameter int START_HI_MIN  = 20,
  parameter int START_HI_MAX  = 33,
  parameter int START_TOT_MIN = 141,
  parameter int START_TOT_MAX = 154,
  parameter int ONE_LO_MIN    = 13,
  parameter int ONE_LO_MAX    = 26,
  parameter int ZERO_LO_MIN   = 43,
  parameter int ZERO_LO_MAX   = 56,
  parameter int BIT_TOT_MIN   = 67,
  parameter int BIT_HI_MAX    = 92,
  parameter int ERR_LO        = 111,
  parameter int ACK_LO        = 49,
  localparam int IDX_W        = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cec_in,
  output logic             ack_pull,
  input  logic [4:0]       own_addr,
  input  logic             cmd_wr,
  input  logic [1:0]       cmd,
  input  logic             clr_buf,
  input  logic             irq_clr,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data,
  output logic [1:0]       rx_status,
  output logic [IDX_W-1:0] rx_len,
  output logic [CNT_W-1:0] rx_count,
  output logic             rx_irq
);
  localparam int TW = $clog2(START_TOT_MAX + 1) + 1;
  localparam logic [TW-1:0] SLO_MIN = TW'(START_LO_MIN);
  localparam logic [TW-1:0] SLO_MAX = TW'(START_LO_MAX);
  localparam logic [TW-1:0] SHI_MIN = TW'(START_HI_MIN);
  localparam logic [TW-1:0] SHI_MAX = TW'(START_HI_MAX);
  localparam logic [TW-1:0] STO_MIN = TW'(START_TOT_MIN);
  localparam logic [TW-1:0] STO_MAX = TW'(START_TOT_MAX);
  localparam logic [TW-1:0] L1_MIN  = TW'(ONE_LO_MIN);
  localparam logic [TW-1:0] L1_MAX  = TW'(ONE_LO_MAX);
  localparam logic [TW-1:0] L0_MIN  = TW'(ZERO_LO_MIN);
  localparam logic [TW-1:0] L0_MAX  = TW'(ZERO_LO_MAX);
  localparam logic [TW-1:0] BT_MIN  = TW'(BIT_TOT_MIN);
  localparam logic [TW-1:0] BH_MAX  = TW'(BIT_HI_MAX);
  localparam logic [TW-1:0] E_LO    = TW'(ERR_LO);
  localparam logic [TW-1:0] A_LO    = TW'(ACK_LO);
  localparam logic [IDX_W:0] FULL   = (IDX_W+1)'(DEPTH);

  localparam logic [1:0] RS_IDLE = 2'd0, RS_BUSY = 2'd1, RS_DONE = 2'd2, RS_ERR = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_SLO, S_SHI, S_BLO, S_BHI} st_t;

  st_t             st;
  logic            s1, s2, s3;
  logic [TW-1:0]   timer, lo_q;
  logic [3:0]      bitn;
  logic [7:0]      shreg;
  logic            eom_q, acc, mine, ack_q;
  logic [IDX_W:0]  wcnt;
  logic [1:0]      cmd_q;
  logic [7:0]      mem [DEPTH];

  wire             fall    = s3 & ~s2;
  wire             rise    = ~s3 & s2;
  wire [TW-1:0]    hi      = timer - lo_q;
  wire [IDX_W:0]   wlast   = wcnt - (IDX_W+1)'(1);
  wire             blocked = clr_buf | (cmd_q == 2'd2) | rx_status[1];
  wire             is_one  = (timer >= L1_MIN) && (timer <= L1_MAX);
  wire             is_zero = (timer >= L0_MIN) && (timer <= L0_MAX);
  wire             lo_bad  = !(is_one || is_zero);
  wire             start_ok = (lo_q >= SLO_MIN) && (lo_q <= SLO_MAX) &&
                              (hi >= SHI_MIN) && (hi <= SHI_MAX) &&
                              (timer >= STO_MIN) && (timer <= STO_MAX);
  wire             dest_own = own_addr[4] && (shreg[3:0] == own_addr[3:0]);
  wire             hdr_ok   = own_addr[4] && (dest_own || shreg[3:0] == 4'hF);

  logic bit_err, got_bit, ovf, fail, fin;

  always_comb begin
    bit_err = 1'b0;
    got_bit = 1'b0;
    if (st == S_BLO) begin
      bit_err = (timer >= E_LO) || (rise && lo_bad);
      got_bit = rise && !lo_bad && (timer < E_LO);
    end else if (st == S_BHI) begin
      bit_err = (hi > BH_MAX) || (fall && timer < BT_MIN);
    end
    ovf  = got_bit && (bitn == 4'd8) && (wcnt == FULL);
    fail = bit_err || ovf;
    fin  = got_bit && (bitn == 4'd9) && eom_q;
  end

  assign ack_pull = ack_q;
  assign rd_data  = mem[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      {s1, s2, s3} <= 3'b111;
      timer <= '0;
      lo_q <= '0;
      bitn <= '0;
      shreg <= '0;
      eom_q <= 1'b0;
      acc <= 1'b0;
      mine <= 1'b0;
      ack_q <= 1'b0;
      wcnt <= '0;
      cmd_q <= '0;
      rx_status <= RS_IDLE;
      rx_len <= '0;
      rx_count <= '0;
      rx_irq <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      {s1, s2, s3} <= {cec_in, s1, s2};
      if (fall) timer <= '0;
      else if (tick && timer != '1) timer <= timer + TW'(1);
      if (cmd_wr) cmd_q <= cmd;
      if (irq_clr) rx_irq <= 1'b0;
      if (cmd_wr && cmd[0] && rx_status[1]) begin
        rx_status <= RS_IDLE;
        if (rx_status == RS_DONE && rx_count != '0) rx_count <= rx_count - CNT_W'(1);
      end

      if (clr_buf) begin
        st <= S_IDLE;
        acc <= 1'b0;
        ack_q <= 1'b0;
        wcnt <= '0;
        rx_status <= RS_IDLE;
        rx_len <= '0;
        rx_count <= '0;
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (cmd_q == 2'd2 && st != S_IDLE) begin
        st <= S_IDLE;
        acc <= 1'b0;
        ack_q <= 1'b0;
        if (rx_status == RS_BUSY) rx_status <= RS_IDLE;
      end else if (fail) begin
        st <= S_IDLE;
        ack_q <= 1'b0;
        acc <= 1'b0;
        if (acc) begin
          rx_status <= RS_ERR;
          rx_len <= wlast[IDX_W-1:0];
          rx_irq <= 1'b1;
        end
      end else if (fin) begin
        st <= S_IDLE;
        ack_q <= 1'b0;
        acc <= 1'b0;
        rx_status <= RS_DONE;
        rx_len <= wlast[IDX_W-1:0];
        if (rx_count != '1) rx_count <= rx_count + CNT_W'(1);
        rx_irq <= 1'b1;
      end else begin
        case (st)
          S_IDLE: if (fall && !blocked) st <= S_SLO;
          S_SLO: begin
            if (rise) begin
              lo_q <= timer;
              st <= S_SHI;
            end else if (timer > SLO_MAX) st <= S_IDLE;
          end
          S_SHI: begin
            if (fall) begin
              if (start_ok) begin
                st <= S_BLO;
                bitn <= '0;
                wcnt <= '0;
                mine <= 1'b0;
              end else st <= S_SLO;
            end else if (hi > SHI_MAX) st <= S_IDLE;
          end
          S_BLO: begin
            if (ack_q && timer >= A_LO) ack_q <= 1'b0;
            if (got_bit) begin
              lo_q <= timer;
              st <= S_BHI;
              if (bitn < 4'd8) shreg <= {shreg[6:0], is_one};
              else if (bitn == 4'd8) begin
                eom_q <= is_one;
                if (wcnt == '0) begin
                  if (hdr_ok) begin
                    acc <= 1'b1;
                    mine <= dest_own;
                    rx_status <= RS_BUSY;
                    mem[0] <= shreg;
                    wcnt <= (IDX_W+1)'(1);
                  end else st <= S_IDLE;
                end else begin
                  mem[wcnt[IDX_W-1:0]] <= shreg;
                  wcnt <= wcnt + (IDX_W+1)'(1);
                end
              end
            end
          end
          S_BHI: begin
            if (fall) begin
              st <= S_BLO;
              bitn <= (bitn == 4'd9) ? 4'd0 : bitn + 4'd1;
              if (bitn == 4'd8 && mine) ack_q <= 1'b1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module cec_frame_rx_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack_pull,
  input logic             rel_wr,
  input logic             clr_buf,
  input logic             irq_clr,
  input logic [1:0]       rx_status,
  input logic [CNT_W-1:0] rx_count,
  input logic             rx_irq
);
  // R6
  ack_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pull |-> rx_status == 2'd1);

  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) |-> rx_status[1]);

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count > $past(rx_count)) |-> rx_status == 2'd2);

  // R11
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_buf |=> (rx_status == 2'd0 && rx_count == '0));

  // R12
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq && !irq_clr) |=> rx_irq);

  // R9
  pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_status[1] && !clr_buf && !rel_wr) |=> rx_status == $past(rx_status));
endmodule

bind cec_frame_rx cec_frame_rx_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_pull(ack_pull), .rel_wr(cmd_wr & cmd[0]),
  .clr_buf(clr_buf), .irq_clr(irq_clr), .rx_status(rx_status),
  .rx_count(rx_count), .rx_irq(rx_irq));

// File: tb/cec_frame_rx_test.sv
module cec_frame_rx_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       drv = 1'b1;
  logic       ack_pull;
  logic [4:0] own_addr = 5'h14;
  logic       cmd_wr = 1'b0;
  logic [1:0] cmd = 2'd0;
  logic       clr_buf = 1'b0;
  logic       irq_clr = 1'b0;
  logic [3:0] rd_idx = '0;
  logic [7:0] rd_data;
  logic [1:0] rx_status;
  logic [3:0] rx_len;
  logic [3:0] rx_count;
  logic       rx_irq;
  wire        line = drv & ~ack_pull;

  cec_frame_rx uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cec_in(line), .ack_pull(ack_pull),
    .own_addr(own_addr), .cmd_wr(cmd_wr), .cmd(cmd), .clr_buf(clr_buf),
    .irq_clr(irq_clr), .rd_idx(rd_idx), .rd_data(rd_data), .rx_status(rx_status),
    .rx_len(rx_len), .rx_count(rx_count), .rx_irq(rx_irq));

  int nchk = 0, nerr = 0;
  logic [7:0]  frm [20];
  logic [19:0] ackv;
  int flen, bad_pos = -1, bad_lo = 0, bad_tot = 0, st_lo = 121, st_tot = 148;
  logic [1:0] mid_status;

  task automatic wait_t(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input int lo, input int tot);
    drv = 1'b0; wait_t(lo); drv = 1'b1; wait_t(tot - lo);
  endtask

  task automatic send_frame();
    ackv = '0;
    mid_status = 2'd0;
    send_bit(st_lo, st_tot);
    for (int i = 0; i < flen; i++) begin
      for (int k = 0; k < 10; k++) begin
        int p, lo, tot;
        logic b;
        p = i * 10 + k;
        if (i == 1 && k == 0) mid_status = rx_status;
        if (k < 8) b = frm[i][7-k];
        else if (k == 8) b = (i == flen - 1);
        else b = 1'b1;
        lo = b ? 20 : 50;
        tot = 73;
        if (p == bad_pos) begin lo = bad_lo; tot = bad_tot; end
        if (k == 9 && p != bad_pos) begin
          drv = 1'b0; wait_t(20); drv = 1'b1; wait_t(14);
          ackv[i] = ~line;
          wait_t(39);
        end else send_bit(lo, tot);
      end
    end
    wait_t(30);
    bad_pos = -1; st_lo = 121; st_tot = 148;
  endtask

  function automatic logic accepts(input logic [7:0] h, input logic [4:0] c);
    return c[4] && (h[3:0] == c[3:0] || h[3:0] == 4'hF);
  endfunction

  function automatic logic acks(input logic [7:0] h, input logic [4:0] c);
    return c[4] && (h[3:0] == c[3:0]);
  endfunction

  task automatic fill(input int n, input logic [3:0] dest);
    flen = n;
    for (int i = 0; i < n; i++) frm[i] = 8'($urandom);
    frm[0][3:0] = dest;
  endtask

  task automatic command(input logic [1:0] c);
    @(negedge clk); cmd = c; cmd_wr = 1'b1;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic release_all();
    command(2'd1); clear_irq(); wait_t(2);
  endtask

  task automatic check_stored(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      rd_idx = 4'(i); wait_t(1);
      chk(req, rd_data, frm[i]);
    end
  endtask

  task automatic check_result(input string req);
    logic a, m;
    a = accepts(frm[0], own_addr);
    m = acks(frm[0], own_addr);
    if (a) begin
      chk({req, " R7 status"}, rx_status, 2);
      chk({req, " R7 len"}, rx_len, flen - 1);
      chk({req, " R7 count"}, rx_count, 1);
      chk({req, " R7 irq"}, rx_irq, 1);
      check_stored({req, " R3 data"}, flen);
      for (int i = 0; i < flen; i++) chk({req, " R6 ack"}, ackv[i], m);
    end else begin
      chk({req, " R5 status"}, rx_status, 0);
      chk({req, " R5 count"}, rx_count, 0);
      chk({req, " R6 no ack"}, ackv[0], 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    wait_t(5); rst_n = 1'b1; wait_t(3);
    // R1
    chk("R1 status", rx_status, 0); chk("R1 len", rx_len, 0);
    chk("R1 count", rx_count, 0); chk("R1 irq", rx_irq, 0);
    chk("R1 ack_pull", ack_pull, 0);

    // R3 R6 R7 R13: own-addressed three-byte frame
    fill(3, 4'h4); send_frame();
    check_result("own3");
    chk("R13 busy mid-frame", mid_status, 1);

    // R9: pending message blocks new frames
    frm[0] = 8'h04; frm[1] = 8'hAA; flen = 2; send_frame();
    chk("R9 blocked ack", ackv[0], 0);
    chk("R9 blocked status", rx_status, 2);
    chk("R9 blocked count", rx_count, 1);
    command(2'd1); wait_t(2);
    chk("R9 release status", rx_status, 0);
    chk("R9 release count", rx_count, 0);
    chk("R12 irq held after release", rx_irq, 1);
    clear_irq(); wait_t(1);
    chk("R12 irq cleared", rx_irq, 0);

    // R5: foreign address and invalid own address
    fill(2, 4'h7); send_frame(); check_result("foreign");
    own_addr = 5'h04; fill(2, 4'h4); send_frame();
    chk("R5 invalid own status", rx_status, 0);
    chk("R5 invalid own ack", ackv[0], 0);
    own_addr = 5'h14;

    // R5 R6: broadcast stored, not acknowledged
    fill(2, 4'hF); send_frame(); check_result("bcast");
    release_all();

    // R2: start windows checked independently
    fill(2, 4'h4); st_lo = 118; st_tot = 139; send_frame();
    chk("R2 short period status", rx_status, 0);
    chk("R2 short period ack", ackv[0], 0);
    fill(2, 4'h4); st_lo = 121; st_tot = 161; send_frame();
    chk("R2 long high status", rx_status, 0);
    fill(2, 4'h4); st_lo = 100; st_tot = 127; send_frame();
    chk("R2 short low status", rx_status, 0);

    // R4: bit errors of each kind
    fill(3, 4'h4); bad_pos = 12; bad_lo = 33; bad_tot = 73; send_frame();
    chk("R4 gap low status", rx_status, 3);
    chk("R4 gap low irq", rx_irq, 1);
    chk("R4 gap low count", rx_count, 0);
    release_all();
    fill(3, 4'h4); bad_pos = 14; bad_lo = 118; bad_tot = 140; send_frame();
    chk("R4 long low status", rx_status, 3);
    release_all();
    fill(3, 4'h4); bad_pos = 11; bad_lo = 20; bad_tot = 58; send_frame();
    chk("R4 short period status", rx_status, 3);
    release_all();
    fill(3, 4'h4); bad_pos = 13; bad_lo = 20; bad_tot = 140; send_frame();
    chk("R4 long high status", rx_status, 3);
    release_all();

    // R8: overflow past 16 bytes
    fill(17, 4'h4); send_frame();
    chk("R8 overflow status", rx_status, 3);
    chk("R8 overflow len", rx_len, 15);
    check_stored("R8 kept bytes", 16);
    release_all();

    // R7: exactly 16 bytes, and a header-only frame
    fill(16, 4'h4); send_frame(); check_result("max16");
    release_all();
    fill(1, 4'h4); send_frame(); check_result("poll");
    release_all();

    // R10: suspend then resume
    command(2'd2);
    fill(2, 4'h4); send_frame();
    chk("R10 suspended status", rx_status, 0);
    chk("R10 suspended ack", ackv[0], 0);
    command(2'd0);
    fill(2, 4'h4); send_frame(); check_result("resume R10");

    // R11: clear empties and ignores the bus
    @(negedge clk); clr_buf = 1'b1; wait_t(3);
    chk("R11 status", rx_status, 0); chk("R11 count", rx_count, 0);
    chk("R11 len", rx_len, 0);
    rd_idx = 4'd0; wait_t(1); chk("R11 byte zero", rd_data, 0);
    clear_irq();
    fill(2, 4'h4); send_frame();
    chk("R11 bus ignored ack", ackv[0], 0);
    chk("R11 bus ignored status", rx_status, 0);
    @(negedge clk); clr_buf = 1'b0; wait_t(2);
    fill(2, 4'h4); send_frame(); check_result("after clear R11");
    command(2'd3); wait_t(2);
    chk("R9 cmd3 status", rx_status, 0);
    clear_irq();

    // random frames: R3 R5 R6 R7
    for (int r = 0; r < 6; r++) begin
      logic [3:0] a, d;
      int pick;
      a = 4'($urandom % 15);
      own_addr = {1'b1, a};
      pick = int'($urandom % 3);
      d = (pick == 0) ? a : (pick == 1) ? 4'hF : 4'(a + 4'd1);
      if (d == 4'hF && pick != 1) d = 4'h0;
      fill(1 + int'($urandom % 5), d);
      send_frame();
      check_result("random");
      release_all();
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule